// File: doc/BRIEF.md
# Dual-Output Masked Interrupt Controller

This block gathers up to 32 level-sensitive interrupt sources into one raw vector. It drives two request lines from that vector: a normal request and a fast request. Each line has its own enable mask, so software can route any source to either line, to both, or to neither. Each mask is changed through a write-one-to-set word and a write-one-to-clear word. A bit written as zero leaves the mask bit it lines up with unchanged.

Software can also raise a request of its own on source 0. The soft request is held in its own latch, and raw bit 0 is the OR of that latch with external line 0. A hardware level on line 0 therefore never hides or cancels the soft request. The register port is word-indexed and completes a write in one clock. Read data is combinational from the index and the current state. The two request lines are registered.

Top module: `dual_mask_intc`

## Requirements
- R1: A synchronous active-high reset clears both enable masks and the soft latch. Both request lines are low on the first clock after reset.
- R2: Writing word index 2 ORs the written value into the normal-request mask. Reading index 2 returns that mask.
- R3: Writing word index 3 clears each normal-request mask bit whose written bit is 1. All other mask bits are left unchanged.
- R4: Word indices 10 and 11 set and clear the fast-request mask in the same way, and reading index 10 returns that mask. Writes to either mask never change the other mask.
- R5: Reading index 0 returns raw AND the normal mask. Reading index 8 returns raw AND the fast mask. Reading index 1 or index 9 returns the unmasked raw vector.
- R6: Writing index 4 with bit 0 set raises the soft latch, and writing index 5 with bit 0 set drops it. Writes to either index with bit 0 clear change nothing. Raw bit 0 is the soft latch ORed with source line 0. Reading index 4 returns raw bit 0 in bit 0 and zeros in all other bits.
- R7: The normal request line is high exactly when some bit of raw AND the normal mask is 1. It is registered and changes one clock after the source change or mask write that causes it.
- R8: The fast request line follows raw AND the fast mask in the same way as R7, independently of the normal line.
- R9: Reads of indices 3, 5 and 11, and of any index outside 0–2, 4, 8–10, return zero.
- R10: Writes to indices 0, 1, 8 and 9, and to any index not listed in R2–R6, leave both masks and the soft latch unchanged.
- R11: A raw bit follows its source line level. It is 1 while the line is high and 0 as soon as the line is low, with nothing latched.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_i | input | NSRC | Level-sensitive source lines |
| wr_en_i | input | 1 | Register write strobe, one clock per write |
| addr_i | input | AW | Word index of the accessed register |
| wdata_i | input | DW | Write data |
| rdata_o | output | DW | Read data for addr_i, combinational |
| irq_o | output | 1 | Normal request line, registered |
| fiq_o | output | 1 | Fast request line, registered |

## Verification
A corrupted mask bit shows at once on the readback of index 2 or 10. It also shows in the masked views at index 0 or 8, and on the request line one clock after the matching source goes high. A soft latch that is stuck or lost appears immediately in bit 0 of index 4, 1 and 9. A write decoded to the wrong index shows up as a change in the other side's mask readback right after that write. Each directed scenario therefore reads the state back through the normal port after every stimulus. It also watches both lines one clock after each change.

// File: rtl/dual_mask_intc.sv
module dual_mask_intc #(
  parameter int NSRC = 32,
  parameter int DW   = 32,
  parameter int AW   = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [NSRC-1:0] src_i,
  input  logic            wr_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [DW-1:0]   wdata_i,
  output logic [DW-1:0]   rdata_o,
  output logic            irq_o,
  output logic            fiq_o
);

  localparam logic [AW-1:0] IX_NSTAT = AW'(0);
  localparam logic [AW-1:0] IX_NRAW  = AW'(1);
  localparam logic [AW-1:0] IX_NSET  = AW'(2);
  localparam logic [AW-1:0] IX_NCLR  = AW'(3);
  localparam logic [AW-1:0] IX_SWSET = AW'(4);
  localparam logic [AW-1:0] IX_SWCLR = AW'(5);
  localparam logic [AW-1:0] IX_FSTAT = AW'(8);
  localparam logic [AW-1:0] IX_FRAW  = AW'(9);
  localparam logic [AW-1:0] IX_FSET  = AW'(10);
  localparam logic [AW-1:0] IX_FCLR  = AW'(11);

  logic [NSRC-1:0] nmask_q, nmask_d, fmask_q, fmask_d;
  logic [NSRC-1:0] raw, raw_d, wbits;
  logic            sw_q, sw_d;

  assign wbits = wdata_i[NSRC-1:0];
  assign raw   = src_i | NSRC'(sw_q);
  assign raw_d = src_i | NSRC'(sw_d);

  always_comb begin
    nmask_d = nmask_q;
    fmask_d = fmask_q;
    sw_d    = sw_q;
    if (wr_en_i) begin
      case (addr_i)
        IX_NSET:  nmask_d = nmask_q | wbits;
        IX_NCLR:  nmask_d = nmask_q & ~wbits;
        IX_FSET:  fmask_d = fmask_q | wbits;
        IX_FCLR:  fmask_d = fmask_q & ~wbits;
        IX_SWSET: if (wdata_i[0]) sw_d = 1'b1;
        IX_SWCLR: if (wdata_i[0]) sw_d = 1'b0;
        default:  ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      nmask_q <= '0;
      fmask_q <= '0;
      sw_q    <= 1'b0;
      irq_o   <= 1'b0;
      fiq_o   <= 1'b0;
    end else begin
      nmask_q <= nmask_d;
      fmask_q <= fmask_d;
      sw_q    <= sw_d;
      irq_o   <= |(raw_d & nmask_d);
      fiq_o   <= |(raw_d & fmask_d);
    end
  end

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      IX_NSTAT: rdata_o = DW'(raw & nmask_q);
      IX_NRAW:  rdata_o = DW'(raw);
      IX_NSET:  rdata_o = DW'(nmask_q);
      IX_SWSET: rdata_o = DW'(raw[0]);
      IX_FSTAT: rdata_o = DW'(raw & fmask_q);
      IX_FRAW:  rdata_o = DW'(raw);
      IX_FSET:  rdata_o = DW'(fmask_q);
      default:  rdata_o = '0;
    endcase
  end

  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> !irq_o && !fiq_o); // R1
  AST_NSET_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == IX_NSET) |=> ((nmask_q & $past(wbits)) == $past(wbits))); // R2
  AST_NCLR_DROPS: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == IX_NCLR) |=> ((nmask_q & $past(wbits)) == '0)); // R3
  AST_FSIDE_APART: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (addr_i == IX_FSET || addr_i == IX_FCLR)) |=> $stable(nmask_q)); // R4
  AST_NSIDE_APART: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (addr_i == IX_NSET || addr_i == IX_NCLR)) |=> $stable(fmask_q)); // R4
  AST_SW_RAISE: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && addr_i == IX_SWSET && wdata_i[0]) |=> raw[0]); // R6
  AST_NOEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (nmask_q == '0 && !(wr_en_i && addr_i == IX_NSET)) |=> !irq_o); // R7
  AST_FNOEN_QUIET: assert property (@(posedge clk) disable iff (rst)
    (fmask_q == '0 && !(wr_en_i && addr_i == IX_FSET)) |=> !fiq_o); // R8
  AST_RO_INERT: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && (addr_i == IX_NSTAT || addr_i == IX_NRAW || addr_i == IX_FSTAT || addr_i == IX_FRAW))
    |=> $stable(nmask_q) && $stable(fmask_q) && $stable(sw_q)); // R10

endmodule

// File: tb/tb_dual_mask_intc.sv
module tb_dual_mask_intc;
  localparam int NSRC = 32;
  localparam int DW   = 32;
  localparam int AW   = 6;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic [NSRC-1:0] src = '0;
  logic            wr_en = 1'b0;
  logic [AW-1:0]   addr = '0;
  logic [DW-1:0]   wdata = '0;
  logic [DW-1:0]   rdata;
  logic            irq, fiq;

  int n_cmp = 0;
  int n_bad = 0;
  logic [DW-1:0] rd;

  dual_mask_intc #(.NSRC(NSRC), .DW(DW), .AW(AW)) dut (
    .clk(clk), .rst(rst), .src_i(src), .wr_en_i(wr_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .irq_o(irq), .fiq_o(fiq));

  always #10 clk = ~clk;

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [DW-1:0] v);
    @(negedge clk);
    wr_en = 1'b1; addr = AW'(idx); wdata = v;
    @(posedge clk); #1;
    wr_en = 1'b0; wdata = '0;
  endtask

  task automatic rdr(input int idx, output logic [DW-1:0] v);
    @(negedge clk);
    addr = AW'(idx);
    #1 v = rdata;
  endtask

  task automatic drive_src(input logic [NSRC-1:0] v);
    @(negedge clk);
    src = v;
    @(posedge clk); #1;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    check("R1 irq after reset", DW'(irq), 0);
    check("R1 fiq after reset", DW'(fiq), 0);
    @(negedge clk); rst = 1'b0;
    rdr(2, rd);  check("R1 nmask zero", rd, 0);
    rdr(10, rd); check("R1 fmask zero", rd, 0);
    rdr(4, rd);  check("R1 soft zero", rd, 0);
  endtask

  task automatic t_masks;
    wr(2, 32'h0000_00F0);
    rdr(2, rd); check("R2 nmask set", rd, 32'h0000_00F0);
    wr(2, 32'h8000_0001);
    rdr(2, rd); check("R2 nmask OR", rd, 32'h8000_00F1);
    wr(3, 32'h0000_0030);
    rdr(2, rd); check("R3 nmask clr only addressed", rd, 32'h8000_00C1);
    wr(3, 32'h0);
    rdr(2, rd); check("R3 zero clr no change", rd, 32'h8000_00C1);
    wr(10, 32'h0F00_0000);
    rdr(10, rd); check("R4 fmask set", rd, 32'h0F00_0000);
    rdr(2, rd);  check("R4 nmask untouched by fset", rd, 32'h8000_00C1);
    wr(11, 32'h0300_0000);
    rdr(10, rd); check("R4 fmask clr", rd, 32'h0C00_0000);
    rdr(2, rd);  check("R4 nmask untouched by fclr", rd, 32'h8000_00C1);
    wr(3, 32'hFFFF_FFFF);
    rdr(10, rd); check("R4 fmask untouched by nclr", rd, 32'h0C00_0000);
    wr(11, 32'hFFFF_FFFF);
  endtask

  task automatic t_status_lines;
    wr(2, 32'h0000_0044);
    wr(10, 32'h0000_4400);
    drive_src(32'h0000_0404);
    check("R7 irq high", DW'(irq), 1);
    check("R8 fiq high", DW'(fiq), 1);
    rdr(0, rd); check("R5 nstat", rd, 32'h0000_0004);
    rdr(8, rd); check("R5 fstat", rd, 32'h0000_0400);
    rdr(1, rd); check("R5 nraw", rd, 32'h0000_0404);
    rdr(9, rd); check("R5 fraw", rd, 32'h0000_0404);
    drive_src(32'h0000_0400);
    check("R7 irq low", DW'(irq), 0);
    check("R8 fiq stays", DW'(fiq), 1);
    wr(11, 32'h0000_0400);
    check("R8 fiq low after fclr", DW'(fiq), 0);
    wr(2, 32'h0000_0400);
    check("R7 irq high after nset", DW'(irq), 1);
    wr(3, 32'hFFFF_FFFF);
    wr(11, 32'hFFFF_FFFF);
    check("R7 irq low no mask", DW'(irq), 0);
    drive_src('0);
  endtask

  task automatic t_soft;
    wr(4, 32'h0000_0002);
    rdr(4, rd); check("R6 set without bit0 inert", rd, 0);
    wr(2, 32'h1);
    wr(4, 32'h1);
    rdr(4, rd); check("R6 soft raised", rd, 1);
    check("R6 soft drives irq", DW'(irq), 1);
    drive_src(32'hFFFF_FFFE);
    rdr(4, rd); check("R6 read only bit0", rd, 1);
    drive_src(32'h1);
    wr(5, 32'h1);
    rdr(1, rd); check("R6 hw line0 keeps raw0", rd, 1);
    drive_src(32'h0);
    rdr(1, rd); check("R6 soft dropped", rd, 0);
    check("R7 irq low after soft drop", DW'(irq), 0);
    wr(4, 32'h1);
    drive_src(32'h1);
    drive_src(32'h0);
    rdr(4, rd); check("R6 hw toggle keeps soft", rd, 1);
    wr(5, 32'h1);
    wr(3, 32'h1);
  endtask

  task automatic t_bad_access;
    wr(2, 32'h0000_0F00);
    wr(10, 32'h00F0_0000);
    drive_src(32'h00F0_0F00);
    rdr(3, rd);  check("R9 idx3 reads zero", rd, 0);
    rdr(5, rd);  check("R9 idx5 reads zero", rd, 0);
    rdr(11, rd); check("R9 idx11 reads zero", rd, 0);
    rdr(6, rd);  check("R9 idx6 reads zero", rd, 0);
    rdr(40, rd); check("R9 idx40 reads zero", rd, 0);
    wr(0, 32'hFFFF_FFFF);
    wr(1, 32'hFFFF_FFFF);
    wr(8, 32'hFFFF_FFFF);
    wr(9, 32'hFFFF_FFFF);
    wr(7, 32'hFFFF_FFFF);
    wr(12, 32'hFFFF_FFFF);
    wr(63, 32'hFFFF_FFFF);
    rdr(2, rd);  check("R10 nmask unchanged", rd, 32'h0000_0F00);
    rdr(10, rd); check("R10 fmask unchanged", rd, 32'h00F0_0000);
    rdr(4, rd);  check("R10 soft unchanged", rd, 0);
    drive_src('0);
    wr(3, 32'hFFFF_FFFF);
    wr(11, 32'hFFFF_FFFF);
  endtask

  task automatic t_level;
    wr(10, 32'h0000_0020);
    drive_src(32'h0000_0020);
    rdr(9, rd); check("R11 raw follows high", rd, 32'h0000_0020);
    check("R8 fiq follows level", DW'(fiq), 1);
    drive_src(32'h0);
    rdr(9, rd); check("R11 raw follows low", rd, 0);
    check("R11 fiq drops with line", DW'(fiq), 0);
    wr(11, 32'hFFFF_FFFF);
  endtask

  initial begin
    t_reset();
    t_masks();
    t_status_lines();
    t_soft();
    t_bad_access();
    t_level();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    #2000000;
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule